// File: doc/BRIEF.md
# Paired Capture/Compare Timer with Cascade and Gate

The block holds two 16-bit up-counting timers that share one external gate pin. Each timer picks its own count source: every system clock cycle, every sixteenth system clock cycle, a rising edge on its own input pin, or a match of the other timer. The last choice lets one timer count the matches of the other, so the pair works as a single 32-bit counter. A timer compares its count with a reference value whenever it advances. On a match it drives its output pin, either as a one-cycle low pulse or as a level toggle. It can also clear its count back to zero on that match.

Each timer latches its current count into a capture register on a chosen edge of its input pin. A match and a capture each set a sticky flag, which software clears by writing a 1. The shared gate can either hold both timers while it is high, or clear them on its falling edge. The input pins and the gate pass through a two-flop synchronizer before any edge is detected. Software reaches the registers through a write strobe and an address. Read data appears one cycle after the address.

Top module: `gated_pair_timer`

## Requirements
- R1: After reset every count, reference, capture and control register is 0, both outputs `tout` are high, all flags are 0 and `rdata` is 0.
- R2: Control bits [1:0] select the count source: 0 advances on every clock, 1 advances once per 16 clocks, 2 advances on a rising edge of the timer's synchronized input pin, and 3 advances on a match of the other timer. Control bit 8 enables counting.
- R3: A match occurs when the timer advances while its count equals its reference. If control bit 5 is set, the count becomes 0 on that advance. Otherwise it increments and wraps from 0xFFFF to 0.
- R4: With control bit 4 clear (pulse mode), `tout` is low for exactly the one cycle that follows each match.
- R5: With control bit 4 set (toggle mode), `tout` inverts once per match and holds its level otherwise.
- R6: A match sets `match_flag` and a capture sets `capt_flag`. Both flags stay set until a write to offset 3 of that timer with wdata bit 0 (match) or bit 1 (capture) set. A new event in the same cycle as the clear wins over the clear.
- R7: Control bits [3:2] choose the capture edges of the synchronized input pin: bit 2 selects rising, bit 3 selects falling, and both bits select either edge. A capture stores the count held before that cycle's update. Edges that are not selected cause no capture.
- R8: With timer 1 on source 3, timer 1 advances exactly once per timer 0 match, so the pair counts as one 32-bit timer.
- R9: Gate mode 1 (control bits [7:6]) lets a timer advance only while the synchronized `gate_n` is low. While it is high the count does not change.
- R10: Gate mode 2 clears the count on a falling edge of the synchronized `gate_n`. The count then keeps running whatever the gate level.
- R11: `tin` and `gate_n` reach the timers through two flip-flops, and a pin edge counts only once.
- R12: Address bit 2 selects the timer and bits [1:0] select the register: 0 control (9 bits), 1 reference, 2 count, 3 capture on read and flag clear on write. Writing offset 2 loads the count, and this write takes priority over all hardware updates. `rdata` shows the addressed register one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address: bit 2 selects the timer, bits [1:0] select the register |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Registered read data |
| tin | input | 2 | Per-timer input pins (count source and capture) |
| gate_n | input | 1 | Shared gate, active low |
| tout | output | 2 | Per-timer compare outputs |
| match_flag | output | 2 | Sticky reference-match flags |
| capt_flag | output | 2 | Sticky capture flags |

## Verification
The counters are exercised with each count source in turn: the free clock, the divide-by-16 enable, pulses on the input pin and the partner's matches. Comparing the resulting counts shows whether the source selection and the single-count-per-edge rule are correct. A short reference with restart, and a long reference that is left to wrap, show the two end-of-count behaviours apart. The same match stream drives pulse mode and toggle mode, which separates the two output shapes. The gate is held high, pulsed low and given falling edges under its hold and restart modes, so that a gate which blocks counting can be told from one that only clears it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CFG_W = 9;

  localparam logic [1:0] SRC_SYS  = 2'd0;
  localparam logic [1:0] SRC_DIV  = 2'd1;
  localparam logic [1:0] SRC_PIN  = 2'd2;
  localparam logic [1:0] SRC_PAIR = 2'd3;

  localparam logic [1:0] GM_OFF     = 2'd0;
  localparam logic [1:0] GM_HOLD    = 2'd1;
  localparam logic [1:0] GM_RESTART = 2'd2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_REF  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CAPT = 2'd3;

  typedef struct packed {
    logic       en;
    logic [1:0] gmode;
    logic       rst_m;
    logic       tog;
    logic [1:0] edg;   // bit0 rising, bit1 falling
    logic [1:0] src;
  } tmr_cfg_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic prv
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {(STAGES+1){RST_VAL}};
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign lvl = sh[STAGES-1];
  assign prv = sh[STAGES];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  AST_DIV_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic          wr_ref,
  input  logic          wr_cnt,
  input  logic          wr_clr,
  input  logic [CW-1:0] wdata,
  input  logic          div_tick,
  input  logic          pin_lvl,
  input  logic          pin_prv,
  input  logic          pair_pulse,
  input  logic          gate_lvl,
  input  logic          gate_prv,
  output tmr_cfg_t      cfg_o,
  output logic [CW-1:0] ref_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] capt_o,
  output logic          tout_o,
  output logic          mflag_o,
  output logic          cflag_o,
  output logic          mpulse_o
);
  tmr_cfg_t      cfg_q;
  logic [CW-1:0] ref_q, cnt_q, capt_q;
  logic          tout_q, mflag_q, cflag_q, mpulse_q;

  logic tick, run, hit, gclr, cap_ev, pin_rise, pin_fall, gate_fall;

  assign pin_rise  = pin_lvl & ~pin_prv;
  assign pin_fall  = ~pin_lvl & pin_prv;
  assign gate_fall = ~gate_lvl & gate_prv;

  always_comb begin
    case (cfg_q.src)
      SRC_SYS:  tick = 1'b1;
      SRC_DIV:  tick = div_tick;
      SRC_PIN:  tick = pin_rise;
      default:  tick = pair_pulse;
    endcase
  end

  assign run    = cfg_q.en && tick && !(cfg_q.gmode == GM_HOLD && gate_lvl);
  assign hit    = run && (cnt_q == ref_q);
  assign gclr   = (cfg_q.gmode == GM_RESTART) && gate_fall;
  assign cap_ev = (cfg_q.edg[0] && pin_rise) || (cfg_q.edg[1] && pin_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ref_q <= '0;
    end else begin
      if (wr_ctrl) cfg_q <= tmr_cfg_t'(wdata[CFG_W-1:0]);
      if (wr_ref)  ref_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (wr_cnt)       cnt_q <= wdata;
    else if (gclr)         cnt_q <= '0;
    else if (run) begin
      if (hit && cfg_q.rst_m) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         capt_q <= '0;
    else if (cap_ev) capt_q <= cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mflag_q  <= 1'b0;
      cflag_q  <= 1'b0;
      mpulse_q <= 1'b0;
      tout_q   <= 1'b1;
    end else begin
      mpulse_q <= hit;
      if (hit)                       mflag_q <= 1'b1;
      else if (wr_clr && wdata[0])   mflag_q <= 1'b0;
      if (cap_ev)                    cflag_q <= 1'b1;
      else if (wr_clr && wdata[1])   cflag_q <= 1'b0;
      if (cfg_q.tog) tout_q <= tout_q ^ hit;
      else           tout_q <= ~hit;
    end
  end

  assign cfg_o    = cfg_q;
  assign ref_o    = ref_q;
  assign cnt_o    = cnt_q;
  assign capt_o   = capt_q;
  assign tout_o   = tout_q;
  assign mflag_o  = mflag_q;
  assign cflag_o  = cflag_q;
  assign mpulse_o = mpulse_q;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hit && cfg_q.rst_m && !wr_cnt && !gclr) |=> (cnt_q == '0)); // R3
  AST_PULSE_AFTER_HIT: assert property (@(posedge clk) disable iff (rst)
    ($past(!cfg_q.tog) && $fell(tout_q)) |-> $past(hit)); // R4
  AST_TOGGLE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_q.tog) && (tout_q != $past(tout_q))) |-> $past(hit)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mflag_q && !(wr_clr && wdata[0])) |=> mflag_q); // R6
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.gmode == GM_HOLD && gate_lvl && !wr_cnt) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/gated_pair_timer.sv
module gated_pair_timer
  import tmr_pkg::*;
#(
  parameter int CW       = 16,
  parameter int DIV      = 16,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [1:0]    tin,
  input  logic          gate_n,
  output logic [1:0]    tout,
  output logic [1:0]    match_flag,
  output logic [1:0]    capt_flag
);
  localparam int NT = 2;

  logic            div_tick, gate_lvl, gate_prv;
  logic [NT-1:0]   pin_lvl, pin_prv, mpulse;
  tmr_cfg_t        cfg_a  [NT];
  logic [CW-1:0]   ref_a  [NT];
  logic [CW-1:0]   cnt_a  [NT];
  logic [CW-1:0]   capt_a [NT];

  tmr_prescale #(.DIV(DIV)) u_pre (.clk(clk), .rst(rst), .tick(div_tick));

  tmr_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_gsync (
    .clk(clk), .rst(rst), .pin(gate_n), .lvl(gate_lvl), .prv(gate_prv));

  for (genvar ch = 0; ch < NT; ch++) begin : g_tmr
    localparam int P = NT - 1 - ch;
    logic sel;
    assign sel = wr_en && (addr[2] == ch[0]);

    tmr_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b0)) u_psync (
      .clk(clk), .rst(rst), .pin(tin[ch]), .lvl(pin_lvl[ch]), .prv(pin_prv[ch]));

    tmr_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_ctrl(sel && addr[1:0] == REG_CTRL),
      .wr_ref (sel && addr[1:0] == REG_REF),
      .wr_cnt (sel && addr[1:0] == REG_CNT),
      .wr_clr (sel && addr[1:0] == REG_CAPT),
      .wdata(wdata), .div_tick(div_tick),
      .pin_lvl(pin_lvl[ch]), .pin_prv(pin_prv[ch]),
      .pair_pulse(mpulse[P]),
      .gate_lvl(gate_lvl), .gate_prv(gate_prv),
      .cfg_o(cfg_a[ch]), .ref_o(ref_a[ch]), .cnt_o(cnt_a[ch]), .capt_o(capt_a[ch]),
      .tout_o(tout[ch]), .mflag_o(match_flag[ch]), .cflag_o(capt_flag[ch]),
      .mpulse_o(mpulse[ch]));
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr[1:0])
        REG_CTRL: rdata <= CW'(cfg_a[addr[2]]);
        REG_REF:  rdata <= ref_a[addr[2]];
        REG_CNT:  rdata <= cnt_a[addr[2]];
        default:  rdata <= capt_a[addr[2]];
      endcase
    end
  end

  AST_CASCADE_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (cfg_a[1].en && cfg_a[1].src == SRC_PAIR && !mpulse[0] &&
     cfg_a[1].gmode == GM_OFF && !(wr_en && addr == 3'd6))
    |=> $stable(cnt_a[1])); // R8
endmodule

// File: tb/tb_gated_pair_timer.sv
module tb_gated_pair_timer;
  logic        clk = 0, rst = 1, wr_en = 0, gate_n = 1;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [1:0]  tin = 0, tout, match_flag, capt_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gated_pair_timer dut (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tin(tin), .gate_n(gate_n), .tout(tout),
    .match_flag(match_flag), .capt_flag(capt_flag));

  // behavioural reference model
  logic [8:0]  m_cfg [2];
  logic [15:0] m_ref [2], m_cnt [2], m_cap [2], m_rd;
  logic [1:0]  m_tout, m_mf, m_cf, m_mp, m_t1, m_t2, m_t3;
  logic        m_g1, m_g2, m_g3;
  int          m_pre;

  always @(posedge clk) begin
    logic dtick, glvl, gfall, tk, rn, gc, cp, w;
    logic [1:0] nmp;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_cfg[i] = 0; m_ref[i] = 0; m_cnt[i] = 0; m_cap[i] = 0;
      end
      m_rd = 0; m_tout = 2'b11; m_mf = 0; m_cf = 0; m_mp = 0;
      m_t1 = 0; m_t2 = 0; m_t3 = 0; m_g1 = 1; m_g2 = 1; m_g3 = 1; m_pre = 0;
    end else begin
      case (addr[1:0])
        0: m_rd = {7'd0, m_cfg[addr[2]]};
        1: m_rd = m_ref[addr[2]];
        2: m_rd = m_cnt[addr[2]];
        default: m_rd = m_cap[addr[2]];
      endcase
      dtick = (m_pre == 15);
      glvl = m_g2; gfall = !m_g2 && m_g3;
      for (int i = 0; i < 2; i++) begin
        logic h;
        case (m_cfg[i][1:0])
          0: tk = 1;
          1: tk = dtick;
          2: tk = m_t2[i] && !m_t3[i];
          default: tk = m_mp[1-i];
        endcase
        rn = m_cfg[i][8] && tk && !(m_cfg[i][7:6] == 1 && glvl);
        h  = rn && (m_cnt[i] == m_ref[i]);
        gc = (m_cfg[i][7:6] == 2) && gfall;
        cp = (m_cfg[i][2] && m_t2[i] && !m_t3[i]) || (m_cfg[i][3] && !m_t2[i] && m_t3[i]);
        w  = wr_en && (addr[2] == i[0]);
        nmp[i] = h;
        if (cp) m_cap[i] = m_cnt[i];
        if (w && addr[1:0] == 2) m_cnt[i] = wdata;
        else if (gc) m_cnt[i] = 0;
        else if (rn) m_cnt[i] = (h && m_cfg[i][5]) ? 16'd0 : m_cnt[i] + 16'd1;
        if (h) m_mf[i] = 1; else if (w && addr[1:0] == 3 && wdata[0]) m_mf[i] = 0;
        if (cp) m_cf[i] = 1; else if (w && addr[1:0] == 3 && wdata[1]) m_cf[i] = 0;
        m_tout[i] = m_cfg[i][4] ? (m_tout[i] ^ h) : !h;
        if (w && addr[1:0] == 0) m_cfg[i] = wdata[8:0];
        if (w && addr[1:0] == 1) m_ref[i] = wdata;
      end
      m_mp = nmp;
      m_t3 = m_t2; m_t2 = m_t1; m_t1 = tin;
      m_g3 = m_g2; m_g2 = m_g1; m_g1 = gate_n;
      m_pre = (m_pre + 1) % 16;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (tout !== m_tout) begin n_fail++;
        $display("FAIL R4 tout act=%b exp=%b", tout, m_tout); end
      if (match_flag !== m_mf) begin n_fail++;
        $display("FAIL R6 match_flag act=%b exp=%b", match_flag, m_mf); end
      if (capt_flag !== m_cf) begin n_fail++;
        $display("FAIL R7 capt_flag act=%b exp=%b", capt_flag, m_cf); end
      if (rdata !== m_rd) begin n_fail++;
        $display("FAIL R12 rdata act=%h exp=%h", rdata, m_rd); end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s act=%0d exp=%0d", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; tin = 0; gate_n = 1; wr_en = 0; addr = 0;
    repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  initial begin
    int v, n;
    do_reset();
    // R1 reset state
    chk(tout == 2'b11 && match_flag == 0 && capt_flag == 0, "R1 outputs", tout, 3);
    rd(3'd2, v); chk(v == 0, "R1 count0", v, 0);
    rd(3'd0, v); chk(v == 0, "R1 ctrl0", v, 0);

    // R2 divide-by-16 and sysclk sources, R12 readback
    wr(3'd1, 16'hFFFF); wr(3'd0, 16'h101);
    rd(3'd0, v); chk(v == 16'h101, "R12 ctrl readback", v, 16'h101);
    rd(3'd1, v); chk(v == 16'hFFFF, "R12 ref readback", v, 16'hFFFF);
    idle(160); rd(3'd2, v); chk(v >= 9 && v <= 12, "R2 div16 count", v, 11);
    do_reset(); wr(3'd1, 16'hFFFF); wr(3'd0, 16'h100);
    idle(50); rd(3'd2, v); chk(v >= 50 && v <= 54, "R2 sysclk count", v, 52);

    // R3/R4 restart at ref 4, pulse output
    do_reset(); wr(3'd1, 16'd4); wr(3'd0, 16'h120);
    n = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (!tout[0]) n++; end
    chk(n >= 19 && n <= 21, "R4 pulse count", n, 20);
    for (int k = 0; k < 4; k++) begin rd(3'd2, v); chk(v <= 4, "R3 restart bound", v, 4); end
    // R3 free wrap
    wr(3'd0, 16'h100); wr(3'd1, 16'h8000); wr(3'd2, 16'hFFFD);
    idle(4); rd(3'd2, v); chk(v < 8, "R3 wrap past 0xFFFF", v, 4);

    // R5 toggle mode, ref 2 restart -> period 3
    do_reset(); wr(3'd1, 16'd2); wr(3'd0, 16'h130);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      logic p; p = tout[0]; @(negedge clk); if (tout[0] != p) n++;
    end
    chk(n >= 19 && n <= 21, "R5 toggles", n, 20);

    // R6 sticky match flag and clear
    do_reset(); wr(3'd1, 16'd10); wr(3'd0, 16'h100);
    idle(30); chk(match_flag[0] == 1, "R6 flag sticky", match_flag[0], 1);
    wr(3'd3, 16'h1); idle(1); chk(match_flag[0] == 0, "R6 flag cleared", match_flag[0], 0);

    // R7 capture on rising only
    do_reset(); wr(3'd1, 16'hFFFF); wr(3'd0, 16'h104);
    idle(5); tin[0] = 1; idle(6);
    chk(capt_flag[0] == 1, "R7 rising capture", capt_flag[0], 1);
    rd(3'd3, v); chk(v > 0 && v < 20, "R7 capture value", v, 10);
    wr(3'd3, 16'h2); idle(1); chk(capt_flag[0] == 0, "R6 capture flag clear", capt_flag[0], 0);
    tin[0] = 0; idle(6); chk(capt_flag[0] == 0, "R7 falling ignored", capt_flag[0], 0);
    wr(3'd0, 16'h10C); tin[0] = 1; idle(6); wr(3'd3, 16'h2); tin[0] = 0; idle(6);
    chk(capt_flag[0] == 1, "R7 both edges", capt_flag[0], 1);

    // R8 cascade
    do_reset(); wr(3'd1, 16'd9); wr(3'd5, 16'hFFFF); wr(3'd4, 16'h103); wr(3'd0, 16'h120);
    idle(200); rd(3'd6, v); chk(v >= 19 && v <= 21, "R8 cascade count", v, 20);

    // R9 gate hold
    do_reset(); wr(3'd1, 16'hFFFF); wr(3'd0, 16'h140);
    idle(20); rd(3'd2, v); chk(v == 0, "R9 held while gate high", v, 0);
    gate_n = 0; idle(10); gate_n = 1; idle(10);
    rd(3'd2, v); chk(v >= 8 && v <= 12, "R9 counted while low", v, 10);

    // R10 gate restart
    do_reset(); wr(3'd1, 16'hFFFF); wr(3'd0, 16'h180);
    idle(50); gate_n = 0; idle(4);
    rd(3'd2, v); chk(v < 10, "R10 cleared on fall", v, 5);
    idle(20); rd(3'd2, v); chk(v >= 20, "R10 runs while low", v, 27);
    gate_n = 1;

    // R11 pin source, one count per edge
    do_reset(); wr(3'd5, 16'hFFFF); wr(3'd4, 16'h102);
    for (int k = 0; k < 3; k++) begin tin[1] = 1; idle(4); tin[1] = 0; idle(4); end
    idle(4); rd(3'd6, v); chk(v == 3, "R11 pin edges", v, 3);
    tin[1] = 1; idle(20); rd(3'd6, v); chk(v == 4, "R2 pin level not counted", v, 4);

    idle(5);
    finish_run();
  end
endmodule